// File: doc/BRIEF.md
# Host Bridge Configuration Register File with Aperture Base Masking

This block holds the 256 byte-wide configuration registers of a host bridge. Software reaches them through a byte-wide port with an 8-bit offset. A write strobe commits one byte on the next clock edge. A read strobe returns the stored byte one cycle later, flagged by a valid pulse. Every offset reads back what it holds. Writes are shaped per offset:
- most registers keep only some of the written bits;
- the status byte clears bits where software writes ones;
- several registers accept writes only while a bit in a gate register is set;
- offsets with no defined write behaviour ignore writes.

The graphics aperture base occupies the upper 16 bits of a 32-bit base, held in offsets 0x12 (bits 23:16) and 0x13 (bits 31:24). How many of its bits are writable depends on a 4-bit size code in offset 0xBC. Whenever either base byte or the size code is written, the whole 16-bit base is ANDed with the mask that the code selects. The new value is stored in the same edge as the write. The size encoding is not linear: code 5 and codes 11 to 15 select no writable bits.

The read path is a two-state machine. `ST_IDLE` moves to `ST_RESP` when a read strobe is sampled. `ST_RESP` stays in `ST_RESP` while strobes keep arriving and returns to `ST_IDLE` when they stop. The valid output is high exactly in `ST_RESP`.

Top module: `apcfg_space`

## Requirements
- R1: After reset these offsets read as follows, and every other offset reads 0x00:
  - 0x00/0x01 read the vendor ID (low byte first) and 0x02/0x03 the device ID;
  - 0x2C–0x2F repeat those four bytes;
  - 0x04 = 0x06, 0x07 = 0x04, 0x0B = 0x06, 0x0D = 0x20;
  - 0x34 = 0xB0, 0x91 = 0x13, 0xE0 = 0x01.
- R2: A read strobe sampled on one edge sets `rd_valid` on the next edge, with `rdata` equal to the byte stored at the offset when the strobe was sampled.
- R3: Plain registers keep only their writable bits: 0x05 keeps 0x01, 0x0D keeps 0xF8, and 0x40 and 0x41 keep 0x7F.
- R4: A write to status byte 0x07 clears each of bits 7:3 written as one. Bits 7:3 written as zero are left as they were, and bits 2:0 never change.
- R5: Bytes 0x2C–0x2F are writable only while bit 0 of gate register 0x90 is set. Byte 0x34 is writable only while bit 1 of 0x90 is set. Otherwise, writes to them are ignored.
- R6: Bytes 0xE0–0xE7 are writable only while bit 5 of 0x90 is set, and 0xE8–0xE9 only while bit 2 is set. Within 0xE0–0xE7, 0xE0 and 0xE1 keep all bits, 0xE2 keeps 0x3F and 0xE3 keeps 0xFE.
- R7: Byte 0x12 keeps only bits 7:6 and byte 0x13 keeps all bits, before the aperture mask is applied. Size register 0xBC keeps bits 3:0.
- R8: The size code selects the writable part of the 16-bit base {0x13,0x12}:
  - 1 → 0xFFF0, 2 → 0xFFE0, 3 → 0xFFC0, 4 → 0xFF80;
  - 6 → 0xFF00, 7 → 0xFE00, 8 → 0xFC00, 9 → 0xF800, 10 → 0xF000.
- R9: Size codes 0, 5 and 11–15 select mask 0x0000, so the base reads zero.
- R10: A write to 0xBC re-masks the base already stored, in the same edge that stores the new code.
- R11: Writes to offsets with no defined write behaviour, such as 0x00, 0x80 and 0xFF, leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, commits `wdata` at `offset` |
| rd_en | input | 1 | Read strobe |
| offset | input | 8 | Register offset for read or write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_valid` is high |
| rd_valid | output | 1 | High one cycle after each sampled read strobe |

## Verification
The bench sweeps the size code through both linear runs, the hole at code 5 and the out-of-range codes. A design with a linear table, an off-by-one shift or no clearing for unused codes would read back a wrong upper base byte. It also shrinks the size after a base is stored, so a design that re-masks only on base writes keeps stale bits. Gated registers are written with the gate clear, then set, then cleared again; a gate wired to the wrong bit or gate register corrupts a stored byte. The status byte takes all-ones and all-zeros writes, and a plain-write implementation changes its low bits.

// File: rtl/apcfg_pkg.sv
package apcfg_pkg;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} rd_state_e;

    localparam logic [7:0] OFF_STATUS  = 8'h07;
    localparam logic [7:0] OFF_BASE_LO = 8'h12;
    localparam logic [7:0] OFF_BASE_HI = 8'h13;
    localparam logic [7:0] OFF_CAPPTR  = 8'h34;
    localparam logic [7:0] OFF_GATE    = 8'h90;
    localparam logic [7:0] OFF_APSIZE  = 8'hBC;

    // {writable, keep-mask} for registers with no gate and no side effect
    function automatic logic [8:0] plain_mask(input logic [7:0] off);
        logic [8:0] r;
        r = 9'h000;
        case (off) inside
            8'h04, 8'h42, [8'h44:8'h45], [8'h47:8'h49], [8'h4B:8'h4F],
            [8'h51:8'h53], [8'h56:8'h5C], 8'h5E, [8'h60:8'h71],
            [8'h84:8'h85], [8'h87:8'h8A], [8'h8C:8'h91], 8'hBB,
            [8'hBE:8'hBF], [8'hC1:8'hC3], [8'hC8:8'hC9], [8'hD2:8'hD3],
            8'hED, 8'hEF, [8'hF5:8'hF6]:  r = 9'h1FF;
            8'h05:                         r = 9'h101;
            8'h0D, 8'h4A:                  r = 9'h1F8;
            8'h40, 8'h41:                  r = 9'h17F;
            8'h43:                         r = 9'h1F7;
            8'h46, 8'hBD:                  r = 9'h1F0;
            8'h50:                         r = 9'h171;
            8'h54:                         r = 9'h13C;
            8'h55:                         r = 9'h11F;
            8'h5D:                         r = 9'h117;
            8'h5F:                         r = 9'h1C1;
            8'h72:                         r = 9'h1C7;
            8'h73:                         r = 9'h11F;
            8'h86:                         r = 9'h10F;
            8'h8B:                         r = 9'h13F;
            8'hB8, 8'hB9:                  r = 9'h103;
            8'hC0:                         r = 9'h190;
            8'hD1:                         r = 9'h1F1;
            8'hEA, 8'hEB:                  r = 9'h1CF;
            8'hEC:                         r = 9'h13F;
            8'hEE:                         r = 9'h13E;
            8'hF3:                         r = 9'h108;
            8'hF7:                         r = 9'h143;
            default:                       r = 9'h000;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] reset_byte(input logic [7:0] off,
                                              input logic [15:0] vid,
                                              input logic [15:0] did);
        logic [7:0] r;
        case (off)
            8'h00, 8'h2C: r = vid[7:0];
            8'h01, 8'h2D: r = vid[15:8];
            8'h02, 8'h2E: r = did[7:0];
            8'h03, 8'h2F: r = did[15:8];
            8'h04, 8'h0B: r = 8'h06;
            8'h07:        r = 8'h04;
            8'h0D:        r = 8'h20;
            8'h34:        r = 8'hB0;
            8'h91:        r = 8'h13;
            8'hE0:        r = 8'h01;
            default:      r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/apcfg_ap_mask.sv
module apcfg_ap_mask #(
    parameter int BASE_W = 16,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [BASE_W-1:0] mask
);
    localparam int SMALL_LO = 1;
    localparam int SMALL_HI = 4;
    localparam int LARGE_LO = 6;
    localparam int LARGE_HI = 10;
    localparam logic [BASE_W-1:0] SMALL_SEED = {{(BASE_W-4){1'b1}}, 4'h0};
    localparam logic [BASE_W-1:0] LARGE_SEED = {{(BASE_W-8){1'b1}}, 8'h00};

    always_comb begin
        mask = '0;
        if (int'(code) >= SMALL_LO && int'(code) <= SMALL_HI)
            mask = SMALL_SEED << (int'(code) - SMALL_LO);
        else if (int'(code) >= LARGE_LO && int'(code) <= LARGE_HI)
            mask = LARGE_SEED << (int'(code) - LARGE_LO);
    end
endmodule

// File: rtl/apcfg_wr_decode.sv
module apcfg_wr_decode
    import apcfg_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic [7:0]        offset,
    input  logic [7:0]        wdata,
    input  logic [7:0]        cur_byte,
    input  logic [3:0]        gate_bits,  // {bit5, bit2, bit1, bit0} of the gate register
    input  logic [3:0]        size_cur,
    input  logic [BASE_W-1:0] base_cur,
    output logic              wr_hit,
    output logic [7:0]        wr_byte,
    output logic              base_upd,
    output logic [BASE_W-1:0] base_next
);
    logic [8:0]        pm;
    logic [3:0]        size_sel;
    logic [BASE_W-1:0] base_raw;
    logic [BASE_W-1:0] ap_mask;

    apcfg_ap_mask #(.BASE_W(BASE_W), .CODE_W(4)) u_mask (
        .code (size_sel),
        .mask (ap_mask)
    );

    always_comb begin
        pm       = plain_mask(offset);
        wr_hit   = pm[8];
        wr_byte  = wdata & pm[7:0];
        base_upd = 1'b0;
        size_sel = size_cur;
        base_raw = base_cur;
        case (offset) inside
            OFF_STATUS: begin
                wr_hit  = 1'b1;
                wr_byte = cur_byte & ~(wdata & 8'hF8);
            end
            OFF_BASE_LO: begin
                wr_hit   = 1'b1;
                wr_byte  = wdata & 8'hC0;
                base_upd = 1'b1;
                base_raw = {base_cur[BASE_W-1:8], wdata & 8'hC0};
            end
            OFF_BASE_HI: begin
                wr_hit   = 1'b1;
                wr_byte  = wdata;
                base_upd = 1'b1;
                base_raw = {wdata, base_cur[7:0]};
            end
            OFF_APSIZE: begin
                wr_hit   = 1'b1;
                wr_byte  = wdata & 8'h0F;
                base_upd = 1'b1;
                size_sel = wdata[3:0];
            end
            [8'h2C:8'h2F], 8'hB7: begin wr_hit = gate_bits[0]; wr_byte = wdata; end
            8'hB4: begin wr_hit = gate_bits[0]; wr_byte = wdata & 8'h03; end
            8'hB5: begin wr_hit = gate_bits[0]; wr_byte = wdata & 8'h02; end
            OFF_CAPPTR: begin wr_hit = gate_bits[1]; wr_byte = wdata; end
            8'hE0, 8'hE1, 8'hE5, 8'hE7: begin wr_hit = gate_bits[3]; wr_byte = wdata; end
            8'hE2: begin wr_hit = gate_bits[3]; wr_byte = wdata & 8'h3F; end
            8'hE3: begin wr_hit = gate_bits[3]; wr_byte = wdata & 8'hFE; end
            8'hE4: begin wr_hit = gate_bits[3]; wr_byte = wdata & 8'h03; end
            8'hE6: begin wr_hit = gate_bits[3]; wr_byte = wdata & 8'hC0; end
            8'hE8, 8'hE9: begin wr_hit = gate_bits[2]; wr_byte = wdata; end
            default: ;
        endcase
        base_next = base_raw & ap_mask;
    end
endmodule

// File: rtl/apcfg_space.sv
module apcfg_space
    import apcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1E3C,
    parameter logic [15:0] DEVICE_ID = 16'h07B2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] offset,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rd_valid
);
    localparam int NREGS  = 256;
    localparam int BASE_W = 16;

    logic [7:0]        regs [NREGS];
    rd_state_e         state_q, state_d;
    logic              wr_hit, base_upd;
    logic [7:0]        wr_byte;
    logic [BASE_W-1:0] base_next;
    logic [7:0]        gate_q, status_q, capptr_q;
    logic [BASE_W-1:0] base_q;
    logic [3:0]        size_q;

    assign gate_q   = regs[OFF_GATE];
    assign status_q = regs[OFF_STATUS];
    assign capptr_q = regs[OFF_CAPPTR];
    assign base_q   = {regs[OFF_BASE_HI], regs[OFF_BASE_LO]};
    assign size_q   = regs[OFF_APSIZE][3:0];

    apcfg_wr_decode #(.BASE_W(BASE_W)) u_dec (
        .offset    (offset),
        .wdata     (wdata),
        .cur_byte  (regs[offset]),
        .gate_bits ({gate_q[5], gate_q[2], gate_q[1], gate_q[0]}),
        .size_cur  (size_q),
        .base_cur  (base_q),
        .wr_hit    (wr_hit),
        .wr_byte   (wr_byte),
        .base_upd  (base_upd),
        .base_next (base_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)
                regs[i] <= reset_byte(8'(i), VENDOR_ID, DEVICE_ID);
        end else if (wr_en) begin
            if (wr_hit)
                regs[offset] <= wr_byte;
            if (base_upd) begin
                regs[OFF_BASE_LO] <= base_next[7:0];
                regs[OFF_BASE_HI] <= base_next[15:8];
            end
        end
    end

    // read-response state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_en)  state_d = ST_RESP;
            ST_RESP: if (!rd_en) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= regs[offset];
    end

    assign rd_valid = (state_q == ST_RESP);
endmodule

// File: rtl/apcfg_checker.sv
module apcfg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  offset,
    input logic [7:0]  wdata,
    input logic        rd_valid,
    input logic [7:0]  gate_q,
    input logic [7:0]  status_q,
    input logic [7:0]  capptr_q,
    input logic [15:0] base_q,
    input logic [3:0]  size_q
);
    function automatic logic [15:0] allowed(input logic [3:0] c);
        case (c)
            4'd1: return 16'hFFF0;  4'd2: return 16'hFFE0;
            4'd3: return 16'hFFC0;  4'd4: return 16'hFF80;
            4'd6: return 16'hFF00;  4'd7: return 16'hFE00;
            4'd8: return 16'hFC00;  4'd9: return 16'hF800;
            4'd10: return 16'hF000;
            default: return 16'h0000;
        endcase
    endfunction

    // R2
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8
    base_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((base_q & ~allowed(size_q)) == 16'h0000));

    // R4
    status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 8'h07) |=>
            (status_q == ($past(status_q) & ~($past(wdata) & 8'hF8))));

    // R5
    capptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == 8'h34 && !gate_q[1]) |=> $stable(capptr_q));

    // R11
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(base_q) && $stable(status_q) && $stable(gate_q)));
endmodule

bind apcfg_space apcfg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .offset   (offset),
    .wdata    (wdata),
    .rd_valid (rd_valid),
    .gate_q   (gate_q),
    .status_q (status_q),
    .capptr_q (capptr_q),
    .base_q   (base_q),
    .size_q   (size_q)
);

// File: tb/sim_apcfg_space.sv
module sim_apcfg_space;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] offset = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] off;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    apcfg_space u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .offset(offset), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
    );

    function automatic logic [15:0] exp_mask(input int code);
        if (code >= 1 && code <= 4)  return 16'hFFF0 << (code - 1);
        if (code >= 6 && code <= 10) return 16'hFF00 << (code - 6);
        return 16'h0000;
    endfunction

    task automatic wr(input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; offset = o; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] o, input logic [7:0] e, input string tag);
        exp_item_t it;
        it.off = o; it.exp = e; it.tag = tag;
        @(negedge clk);
        rd_en = 1'b1; offset = o;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            exp_item_t it;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected rd_valid, actual %h expected none", rdata);
            end else begin
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: offset %h actual %h expected %h",
                             it.tag, it.off, rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: rd_valid after reset actual %b expected 0", rd_valid);
        end

        // R1 reset values
        rd(8'h00, 8'h3C, "R1"); rd(8'h01, 8'h1E, "R1");
        rd(8'h03, 8'h07, "R1"); rd(8'h2E, 8'hB2, "R1");
        rd(8'h04, 8'h06, "R1"); rd(8'h07, 8'h04, "R1");
        rd(8'h0B, 8'h06, "R1"); rd(8'h0D, 8'h20, "R1");
        rd(8'h34, 8'hB0, "R1"); rd(8'h91, 8'h13, "R1");
        rd(8'hE0, 8'h01, "R1"); rd(8'h13, 8'h00, "R1");

        // R3 write masks
        wr(8'h05, 8'hFF); rd(8'h05, 8'h01, "R3");
        wr(8'h0D, 8'hFF); rd(8'h0D, 8'hF8, "R3");
        wr(8'h40, 8'hFF); rd(8'h40, 8'h7F, "R3");
        wr(8'h41, 8'h80); rd(8'h41, 8'h00, "R3");

        // R4 status write-one-to-clear
        wr(8'h07, 8'hFF); rd(8'h07, 8'h04, "R4");
        wr(8'h07, 8'h00); rd(8'h07, 8'h04, "R4");

        // R5 gated subsystem ID and capability pointer
        wr(8'h2C, 8'h55); rd(8'h2C, 8'h3C, "R5");
        wr(8'h90, 8'h01);
        wr(8'h2C, 8'h55); rd(8'h2C, 8'h55, "R5");
        wr(8'h34, 8'h40); rd(8'h34, 8'hB0, "R5");
        wr(8'h90, 8'h02);
        wr(8'h34, 8'h40); rd(8'h34, 8'h40, "R5");
        wr(8'h2C, 8'h66); rd(8'h2C, 8'h55, "R5");

        // R6 gated 0xE0-0xE9
        wr(8'hE0, 8'hAA); rd(8'hE0, 8'h01, "R6");
        wr(8'h90, 8'h20);
        wr(8'hE0, 8'hAA); rd(8'hE0, 8'hAA, "R6");
        wr(8'hE2, 8'hFF); rd(8'hE2, 8'h3F, "R6");
        wr(8'hE3, 8'hFF); rd(8'hE3, 8'hFE, "R6");
        wr(8'hE8, 8'h33); rd(8'hE8, 8'h00, "R6");
        wr(8'h90, 8'h04);
        wr(8'hE8, 8'h33); rd(8'hE8, 8'h33, "R6");
        wr(8'hE1, 8'h77); rd(8'hE1, 8'h00, "R6");

        // R9 code 0 leaves nothing writable
        wr(8'h13, 8'hAB); rd(8'h13, 8'h00, "R9");

        // R7 / R8 base byte masks and size table
        wr(8'hBC, 8'h01);
        wr(8'h13, 8'hAB); rd(8'h13, 8'hAB, "R7");
        wr(8'h12, 8'hFF); rd(8'h12, 8'hC0, "R7");
        for (int c = 1; c <= 10; c++) begin
            logic [15:0] m;
            if (c == 5) continue;
            m = exp_mask(c);
            wr(8'hBC, 8'(c));
            wr(8'h13, 8'hFF);
            wr(8'h12, 8'hFF);
            rd(8'h13, m[15:8], "R8");
            rd(8'h12, 8'hC0 & m[7:0], "R8");
        end

        // R10 shrinking the window re-masks the stored base
        wr(8'hBC, 8'h01); wr(8'h13, 8'hAB); wr(8'h12, 8'hC0);
        wr(8'hBC, 8'h04); rd(8'h12, 8'h80, "R10"); rd(8'h13, 8'hAB, "R10");
        wr(8'hBC, 8'h07); rd(8'h13, 8'hAA, "R10"); rd(8'h12, 8'h00, "R10");
        wr(8'hBC, 8'h0A); rd(8'h13, 8'hA0, "R10");

        // R9 / R7 unused codes clear the base, size keeps 3:0
        wr(8'hBC, 8'h1F); rd(8'hBC, 8'h0F, "R7"); rd(8'h13, 8'h00, "R9");
        wr(8'hBC, 8'h01); wr(8'h13, 8'hFF);
        wr(8'hBC, 8'h05); rd(8'h13, 8'h00, "R9");
        wr(8'hBC, 8'h01); wr(8'h13, 8'hFF);
        wr(8'hBC, 8'h0B); rd(8'h13, 8'h00, "R9");

        // R11 undefined offsets ignore writes
        wr(8'h00, 8'h12); rd(8'h00, 8'h3C, "R11");
        wr(8'h80, 8'h5A); rd(8'h80, 8'h00, "R11");
        wr(8'hFF, 8'h5A); rd(8'hFF, 8'h00, "R11");

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2: pending reads actual %0d expected 0", sb.size());
        end
        finish_run();
    end
endmodule